// File: doc/BRIEF.md
# Cascaded BCD Decade Counter

This block counts in decimal using a chain of decades. Each decade is a plain 4-bit loadable binary counter with an increment enable, a parallel-load path and a hold state. Decode logic around it forces the decade back to zero after nine, so each decade steps 0 through 9. A decade raises a terminal-count signal while it sits at nine and is enabled to advance. That signal enables the next decade, so with the default of three decades the chain counts 000 to 999 and then rolls over to 000.

A parameter selects how the wrap is produced. In the synchronous-load variant, the state nine is decoded and a load of zero is requested, so zero appears on the following edge. In the clear variant, the state ten is decoded and the decade is cleared at once. The binary register briefly holds ten, but the clear masks it in the same cycle, so the port shows zero and the next count starts from zero.

A global load places a preset decimal value into every decade at the same time. Load overrides counting. With neither load nor count asserted, the value holds. A synchronous active-low reset zeroes all decades.

Top module: `bcd_decade_chain`

## Requirements
- R1: While `rst_n` is 0 at a rising clock edge, every digit becomes 0 after that edge.
- R2: With `load_en` 1, the digits take `load_digits` on the next edge. Digit k sits at bits 4k+3..4k, with digit 0 the least significant. Preset digits are in 0..9.
- R3: When `load_en` and `count_en` are both 1, the load wins and no increment happens.
- R4: With `count_en` 1 and `load_en` 0, the decimal value formed by the digits rises by exactly one on the next edge.
- R5: With `count_en` and `load_en` both 0, the digits keep their value across the edge.
- R6: A decade at 9 that is enabled to advance shows 0 after the edge, and the next higher decade advances on the same edge. The full chain wraps from 999 to 000.
- R7: `carry_out` is 1 exactly when `count_en` is 1, `load_en` is 0 and every digit is 9.
- R8: No digit ever shows a value above 9, in either wrap variant.
- R9: The clear variant (`WRAP_MODE` = clear on ten) produces the same digit and `carry_out` sequence at its ports as the synchronous-load variant for any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_en | input | 1 | Advance the chain by one when not loading |
| load_en | input | 1 | Parallel load of all decades, overrides counting |
| load_digits | input | 4*NUM_DECADES | Preset BCD digits, digit 0 in bits 3..0 |
| digits | output | 4*NUM_DECADES | Current BCD digits, digit 0 in bits 3..0 |
| carry_out | output | 1 | Terminal count of the most significant decade |

## Verification
Assertions check on every cycle that no digit leaves 0..9 and that a load lands exactly. They also check that a hold keeps the digits stable, that a count step raises the decimal value by one modulo the chain range, that reset zeroes the chain, and that `carry_out` only rises at the all-nines state with counting enabled. The bench shows things no single-cycle property captures. It drives two instances, one per wrap variant, with the same random stimulus and shows they agree cycle by cycle, including the masked ten state of the clear variant. Directed scenarios show the full 999-to-000 rollover, the interplay of load and count in one cycle, and a reset in the middle of a count.

// File: rtl/bcd_pkg.sv
// Shared types and constants for the decimal counter chain.
// Assumes one BCD digit per 4-bit decade.
package bcd_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
    localparam digit_t DIGIT_TOP  = 4'd9;
    localparam digit_t DIGIT_OVER = 4'd10;

    typedef enum logic {
        WRAP_LOAD_AT_NINE = 1'b0,
        WRAP_CLEAR_AT_TEN = 1'b1
    } wrap_mode_e;
endpackage

// File: rtl/bcd_bin_counter.sv
// Loadable binary up-counter with hold.
// Load has priority over count. When CLR_ON_OVER is set, the register
// value DIGIT_OVER is masked to zero in the same cycle. Both the port and
// the next-state logic see zero, so the transient code never escapes.
// Assumes the caller never loads DIGIT_OVER and expects to see it.
module bcd_bin_counter
    import bcd_pkg::*;
#(
    parameter int W           = DIGIT_W,
    parameter bit CLR_ON_OVER = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         cnt,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_reg;
    logic         clr_now;

    // Immediate clear decode on the stored state (clear variant only).
    always_comb begin
        clr_now = CLR_ON_OVER && (q_reg == W'(DIGIT_OVER));
        q       = clr_now ? '0 : q_reg;
    end

    // State register: reset, then load, then increment, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q_reg <= '0;
        else if (ld)  q_reg <= d;
        else if (cnt) q_reg <= q + 1'b1;
        else          q_reg <= q;
    end
endmodule

// File: rtl/bcd_decade.sv
// One decimal decade: a binary counter plus wrap decode.
// en_in means "advance this decade now". tc is high at nine while en_in
// is high, and it feeds the next decade. The wrap variant is chosen by
// WRAP_MODE. Assumes ext_ld and en_in are never both high (top ensures).
module bcd_decade
    import bcd_pkg::*;
#(
    parameter wrap_mode_e WRAP_MODE = WRAP_LOAD_AT_NINE
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ext_ld,
    input  digit_t ext_d,
    input  logic   en_in,
    output digit_t digit,
    output logic   tc
);
    logic   ctr_ld;
    digit_t ctr_d;

    // Terminal count: at nine and asked to advance.
    always_comb tc = en_in && (digit == DIGIT_TOP);

    generate
        if (WRAP_MODE == WRAP_LOAD_AT_NINE) begin : g_sync_wrap
            // Nine decoded: request a load of zero for the next edge.
            always_comb begin
                ctr_ld = ext_ld || tc;
                ctr_d  = ext_ld ? ext_d : '0;
            end
            bcd_bin_counter #(.W(DIGIT_W), .CLR_ON_OVER(1'b0)) u_ctr (
                .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .cnt(en_in),
                .d(ctr_d), .q(digit)
            );
        end else begin : g_clr_wrap
            // Ten decoded inside the counter and cleared at once.
            always_comb begin
                ctr_ld = ext_ld;
                ctr_d  = ext_d;
            end
            bcd_bin_counter #(.W(DIGIT_W), .CLR_ON_OVER(1'b1)) u_ctr (
                .clk(clk), .rst_n(rst_n), .ld(ctr_ld), .cnt(en_in),
                .d(ctr_d), .q(digit)
            );
        end
    endgenerate
endmodule

// File: rtl/bcd_decade_chain.sv
// Chain of NUM_DECADES decimal decades, least significant first.
// Each decade's terminal count enables the next one. A global load
// presets every decade and suppresses counting in that cycle.
// Assumes preset digits are 0..9.
module bcd_decade_chain
    import bcd_pkg::*;
#(
    parameter int         NUM_DECADES = 3,
    parameter wrap_mode_e WRAP_MODE   = WRAP_LOAD_AT_NINE
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           count_en,
    input  logic                           load_en,
    input  logic [NUM_DECADES*DIGIT_W-1:0] load_digits,
    output logic [NUM_DECADES*DIGIT_W-1:0] digits,
    output logic                           carry_out
);
    localparam int LAST = NUM_DECADES - 1;

    logic [NUM_DECADES-1:0] stage_en;
    logic [NUM_DECADES-1:0] stage_tc;

    // Base enable: counting only when no load is in progress.
    always_comb stage_en[0] = count_en && !load_en;

    genvar k;
    generate
        for (k = 0; k < NUM_DECADES; k++) begin : g_decade
            if (k > 0) begin : g_link
                // Ripple the enable from the lower decade's terminal count.
                always_comb stage_en[k] = stage_tc[k-1];
            end
            bcd_decade #(.WRAP_MODE(WRAP_MODE)) u_decade (
                .clk    (clk),
                .rst_n  (rst_n),
                .ext_ld (load_en),
                .ext_d  (load_digits[k*DIGIT_W +: DIGIT_W]),
                .en_in  (stage_en[k]),
                .digit  (digits[k*DIGIT_W +: DIGIT_W]),
                .tc     (stage_tc[k])
            );
        end
    endgenerate

    // Chain carry comes from the most significant decade.
    always_comb carry_out = stage_tc[LAST];
endmodule

// File: rtl/bcd_decade_chain_chk.sv
// Property checker for the decade chain, bound to every instance.
// Assumes the bench loads only valid BCD presets.
module bcd_decade_chain_chk
    import bcd_pkg::*;
#(
    parameter int NUM_DECADES = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           count_en,
    input logic                           load_en,
    input logic [NUM_DECADES*DIGIT_W-1:0] load_digits,
    input logic [NUM_DECADES*DIGIT_W-1:0] digits,
    input logic                           carry_out
);
    function automatic int pow10(input int n);
        int r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    localparam int MODV = pow10(NUM_DECADES);

    int  value;
    logic all_nine;

    // Decimal value and all-nines flag seen at the ports.
    always_comb begin
        value    = 0;
        all_nine = 1'b1;
        for (int i = NUM_DECADES - 1; i >= 0; i--) begin
            value = value * 10 + int'(digits[i*DIGIT_W +: DIGIT_W]);
            if (digits[i*DIGIT_W +: DIGIT_W] != DIGIT_TOP) all_nine = 1'b0;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> digits == '0);                                        // R1
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> digits == $past(load_digits));                       // R2
    AST_LOAD_BEATS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && count_en |=> digits == $past(load_digits));           // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !load_en |=> value == ($past(value) + 1) % MODV);    // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !count_en && !load_en |=> $stable(digits));                      // R5
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && !load_en && all_nine |=> digits == '0);              // R6
    AST_CARRY_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> count_en && !load_en && all_nine);                 // R7

    genvar k;
    generate
        for (k = 0; k < NUM_DECADES; k++) begin : g_rng
            AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                digits[k*DIGIT_W +: DIGIT_W] <= DIGIT_TOP);              // R8
        end
    endgenerate
endmodule

bind bcd_decade_chain bcd_decade_chain_chk #(.NUM_DECADES(NUM_DECADES)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .load_en(load_en),
    .load_digits(load_digits), .digits(digits), .carry_out(carry_out)
);

// File: tb/bcd_decade_chain_tb.sv
`timescale 1ns/1ps
module bcd_decade_chain_tb;
    import bcd_pkg::*;

    localparam int N    = 3;
    localparam int W    = N * DIGIT_W;
    localparam int MODV = 1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         count_en = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_digits = '0;
    logic [W-1:0] dig_s, dig_c;
    logic         co_s, co_c;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_decade_chain #(.NUM_DECADES(N), .WRAP_MODE(WRAP_LOAD_AT_NINE)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .load_en(load_en),
        .load_digits(load_digits), .digits(dig_s), .carry_out(co_s));

    bcd_decade_chain #(.NUM_DECADES(N), .WRAP_MODE(WRAP_CLEAR_AT_TEN)) u_dut_clr (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .load_en(load_en),
        .load_digits(load_digits), .digits(dig_c), .carry_out(co_c));

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t = v;
        for (int i = 0; i < N; i++) begin
            r[i*DIGIT_W +: DIGIT_W] = DIGIT_W'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int from_bcd(input logic [W-1:0] b);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) r = r * 10 + int'(b[i*DIGIT_W +: DIGIT_W]);
        return r;
    endfunction

    function automatic bit digits_ok(input logic [W-1:0] b);
        for (int i = 0; i < N; i++) if (b[i*DIGIT_W +: DIGIT_W] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check carry, clock, update model, check digits.
    task automatic step(input bit rst, input bit ld, input bit cnt, input int preset);
        string tag;
        @(negedge clk);
        rst_n       = !rst;
        load_en     = ld;
        count_en    = cnt;
        load_digits = to_bcd(preset);
        #1;
        if (!rst) begin
            check_bit("R7 carry_out sync", co_s, cnt && !ld && model == MODV - 1);
            check_bit("R9/R7 carry_out clear", co_c, cnt && !ld && model == MODV - 1);
        end
        if (rst)                        tag = "R1";
        else if (ld && cnt)             tag = "R3";
        else if (ld)                    tag = "R2";
        else if (cnt && model % 10 == 9) tag = "R6";
        else if (cnt)                   tag = "R4";
        else                            tag = "R5";
        @(posedge clk);
        if (rst)      model = 0;
        else if (ld)  model = preset;
        else if (cnt) model = (model + 1) % MODV;
        #1;
        check_vec({tag, " digits sync"}, dig_s, to_bcd(model));
        check_vec({"R9/", tag, " digits clear"}, dig_c, to_bcd(model));
        checks++;
        if (!digits_ok(dig_s) || !digits_ok(dig_c)) begin
            failures++;
            $display("FAIL R8 digit above 9 actual=%h/%h expected<=999 (%0d)",
                     dig_s, dig_c, from_bcd(to_bcd(model)));
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        // R1: reset state.
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        // R4/R6: count through the first decade wrap 9 -> 10 -> 11.
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0);
        // R5: hold.
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R2: load, then R6/R7 full rollover 998 -> 999 -> 000 -> 001.
        step(0, 1, 0, 998);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        // R6: middle decade wrap 099 -> 100.
        step(0, 1, 0, 99);
        step(0, 0, 1, 0);
        // R3: load and count together, including at 999.
        step(0, 1, 0, 999);
        step(0, 1, 1, 512);
        step(0, 1, 1, 0);
        // R5: hold at 9 must not wrap.
        step(0, 1, 0, 9);
        step(0, 0, 0, 0);
        // R1: reset in the middle of counting.
        step(0, 1, 0, 457);
        step(1, 0, 1, 0);
        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(99, 0));
            int p = int'($urandom_range(999, 0));
            bit ld  = (r < 8);
            bit cnt = (r >= 4) && (r < 80);
            bit rs  = (r == 99);
            step(rs, ld, cnt, p);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule